// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block passes a stream of data words from one clock domain to another clock domain that has no fixed relation to it. A producer pushes words on the write clock. A consumer pulls them on the read clock, and the words come out in the order they went in. Storage is a register array with one write port and one read port. The array is used as a ring. The write address and the read address each start at zero after reset, advance by one on every accepted operation, and wrap back to zero after the last entry.

Each side keeps a binary pointer with one extra wrap bit. Each side also keeps a Gray-coded copy of that pointer in a register. Only the Gray copy crosses into the other domain, through a chain of synchronizing flops. Because one step of a Gray code changes only one bit, a sampled copy is either the current pointer or an earlier one. It is never a mix of bits from two values.

The full flag is formed in the write domain and the empty flag in the read domain. Each is computed from that side's own next pointer and the synchronized pointer of the other side. A lagging copy can only make a flag stay asserted longer than needed. It can never make a flag release too soon. A write while full and a read while empty are dropped.

Top module: `cdc_gray_fifo`

## Requirements
- R1: While a reset is held, and until the first accepted operation after it, `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R2: Words leave in exactly the order they were accepted, with no word lost or duplicated. The first accepted write and the first accepted read after reset both use entry 0.
- R3: A read is accepted when `rd_en` is 1 and `empty` is 0 at a read clock edge. `rd_valid` is 1 during the read clock cycle after that edge and `rd_data` holds the word during that cycle. In any other cycle `rd_valid` is 0.
- R4: `full` becomes 1 once 2^ADDR_W words are stored and unread. A write presented while `full` is 1 is dropped. It writes no entry and does not move the write pointer.
- R5: A read presented while `empty` is 1 is dropped. It gives no `rd_valid` pulse and does not move the read pointer.
- R6: `full` is never 0 while 2^ADDR_W words are unread. `empty` is never 0 while no word is unread. The number of unread words never exceeds 2^ADDR_W.
- R7: After a read frees an entry in a full FIFO, `full` returns to 0 within one read clock plus a few write clocks. After a write into an empty FIFO, `empty` returns to 0 within one write clock plus a few read clocks.
- R8: The Gray write pointer that crosses domains changes in at most one bit from one write clock to the next.
- R9: Ordering and flags stay correct when both pointers wrap several times under bursty traffic on unrelated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low, asynchronous assert |
| wr_en | input | 1 | Request to store `wr_data` |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry, so writes are dropped |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low, asynchronous assert |
| rd_en | input | 1 | Request to take the oldest word |
| rd_data | output | DATA_W | Word returned by the previous accepted read |
| rd_valid | output | 1 | `rd_data` is valid this read cycle |
| empty | output | 1 | No unread word, so reads are dropped |

## Verification
Faults in the pointers or the array appear at the read port on the first word that passes through the damaged entry. The symptom is a word out of order, a missing word or a repeated word, so the scoreboard reports it at that read. A wrong wrap-bit comparison shows up as a flag that rises at the wrong fill level. The bench sees that within a few cycles of the 256th write, or of draining the last word. A synchronizer or flag register that never updates shows up as `full` or `empty` stuck beyond the release bound. A Gray encoding fault can corrupt the synchronized copy with no visible effect for a long time. For that reason the one-bit-change property is watched at the source on every write clock.

// File: rtl/cdc_gray_fifo_pkg.sv
package cdc_gray_fifo_pkg;
  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_ADDR_W  = 8;
  localparam int unsigned DEF_SYNC_N  = 2;
endpackage

// File: rtl/cdc_gray_fifo_sync.sv
// Multi-flop synchronizer chain for a Gray-coded pointer.
module cdc_gray_fifo_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cdc_gray_fifo_wside.sv
// Write pointer, Gray copy and full flag.
module cdc_gray_fifo_wside #(
  parameter int unsigned AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [AW:0] rgray_s,
  output logic        full,
  output logic        push,
  output logic [AW:0] wbin,
  output logic [AW:0] wgray
);
  logic [AW:0] bin_d, gray_d;
  logic        full_d;

  assign push = wr_en & ~full;

  always_comb begin
    bin_d  = wbin + {{AW{1'b0}}, push};
    gray_d = bin_d ^ (bin_d >> 1);
    // full: same address, opposite lap -> top two Gray bits inverted
    full_d = (gray_d == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= bin_d;
      wgray <= gray_d;
      full  <= full_d;
    end
  end
endmodule

// File: rtl/cdc_gray_fifo_rside.sv
// Read pointer, Gray copy and empty flag.
module cdc_gray_fifo_rside #(
  parameter int unsigned AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [AW:0] wgray_s,
  output logic        empty,
  output logic        pop,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray
);
  logic [AW:0] bin_d, gray_d;
  logic        empty_d;

  assign pop = rd_en & ~empty;

  always_comb begin
    bin_d   = rbin + {{AW{1'b0}}, pop};
    gray_d  = bin_d ^ (bin_d >> 1);
    empty_d = (gray_d == wgray_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= bin_d;
      rgray <= gray_d;
      empty <= empty_d;
    end
  end
endmodule

// File: rtl/cdc_gray_fifo_mem.sv
// Register-array storage with a registered read port.
module cdc_gray_fifo_mem #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= ram[raddr];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rvalid <= 1'b0;
    else         rvalid <= re;
  end
endmodule

// File: rtl/cdc_gray_fifo.sv
module cdc_gray_fifo
  import cdc_gray_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] wbin, wgray, wgray_s;
  logic [PW-1:0] rbin, rgray, rgray_s;
  logic          push, pop;

  cdc_gray_fifo_wside #(.AW(ADDR_W)) u_wside (
    .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .full(full), .push(push), .wbin(wbin), .wgray(wgray)
  );

  cdc_gray_fifo_rside #(.AW(ADDR_W)) u_rside (
    .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .empty(empty), .pop(pop), .rbin(rbin), .rgray(rgray)
  );

  cdc_gray_fifo_sync #(.W(PW), .STAGES(SYNC_N)) u_sync_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
  );

  cdc_gray_fifo_sync #(.W(PW), .STAGES(SYNC_N)) u_sync_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
  );

  cdc_gray_fifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wclk), .we(push), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .re(pop), .raddr(rbin[ADDR_W-1:0]),
    .rdata(rd_data), .rvalid(rd_valid)
  );
endmodule

// File: rtl/cdc_gray_fifo_chk.sv
module cdc_gray_fifo_chk #(
  parameter int unsigned AW = 8
) (
  input logic        wclk,
  input logic        wrst_n,
  input logic        rclk,
  input logic        rrst_n,
  input logic        rd_en,
  input logic        full,
  input logic        empty,
  input logic        rd_valid,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin,
  input logic [AW:0] wgray
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [AW:0] occ;
  assign occ = wbin - rbin;

  AST_WR_NO_OVERRUN: assert property (@(posedge wclk) disable iff (!wrst_n || !rrst_n)
    occ <= DEPTH_V); // R4
  AST_RD_NO_UNDERRUN: assert property (@(posedge rclk) disable iff (!wrst_n || !rrst_n)
    occ <= DEPTH_V); // R5
  AST_FULL_NOT_EARLY: assert property (@(posedge wclk) disable iff (!wrst_n || !rrst_n)
    !full |-> occ < DEPTH_V); // R6
  AST_EMPTY_NOT_EARLY: assert property (@(posedge rclk) disable iff (!wrst_n || !rrst_n)
    !empty |-> occ != '0); // R6
  AST_GRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R8
  AST_RD_VALID_AFTER_POP: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && !empty) |=> rd_valid); // R3
  AST_NO_VALID_IF_DROPPED: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(rd_en && !empty) |=> !rd_valid); // R5
endmodule

bind cdc_gray_fifo cdc_gray_fifo_chk #(.AW(ADDR_W)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .rd_en(rd_en), .full(full), .empty(empty), .rd_valid(rd_valid),
  .wbin(wbin), .rbin(rbin), .wgray(wgray)
);

// File: tb/cdc_gray_fifo_bench.sv
`timescale 1ns/1ps
module cdc_gray_fifo_bench;
  localparam int DW    = 16;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty, rd_valid;

  int checks = 0, failures = 0;
  logic [DW-1:0] sb [$];
  bit pend = 0, refused = 0, wdone = 0;
  int nwr = 0, nrd = 0;

  always #2.5  wclk = ~wclk;   // 200 MHz write side
  always #3.35 rclk = ~rclk;   // unrelated read side

  cdc_gray_fifo u_cdc_gray_fifo (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty(empty)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_step(input bit en, input logic [DW-1:0] d, output bit acc);
    @(posedge wclk); #1;
    wr_en = en; wr_data = d;
    acc = en && !full;
    if (acc) begin sb.push_back(d); nwr++; end
  endtask

  task automatic rd_step(input bit en);
    logic [DW-1:0] e;
    @(posedge rclk); #1;
    if (pend) begin
      check(rd_valid === 1'b1, "R3", "rd_valid after accepted read", rd_valid, 1);
      if (sb.size() == 0) check(0, "R2", "read with nothing written", rd_data, 0);
      else begin
        e = sb.pop_front();
        check(rd_data === e, "R2", "read order", rd_data, e);
        nrd++;
      end
    end else if (refused) begin
      check(rd_valid === 1'b0, "R5", "read while empty dropped", rd_valid, 0);
    end else begin
      check(rd_valid === 1'b0, "R3", "rd_valid idle", rd_valid, 0);
    end
    rd_en   = en;
    pend    = en && !empty;
    refused = en && empty;
  endtask

  initial begin : watchdog
    #950000;
    failures++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    bit acc;
    int n;
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(posedge wclk);
    #1;
    check(empty === 1'b1, "R1", "empty in reset", empty, 1);
    check(full === 1'b0, "R1", "full in reset", full, 0);
    check(rd_valid === 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    @(posedge wclk); #1 wrst_n = 1'b1;
    @(posedge rclk); #1 rrst_n = 1'b1;
    repeat (4) @(posedge wclk);
    #1;
    check(empty === 1'b1 && full === 1'b0, "R1", "flags after reset", {empty, full}, 2'b10);

    // R5: reads on empty FIFO are dropped
    repeat (3) rd_step(1);
    rd_step(0);
    rd_step(0);
    check(empty === 1'b1, "R5", "empty after dropped reads", empty, 1);

    // R4: fill to capacity, full must not appear early
    n = 0;
    while (n < DEPTH) begin
      if (full) check(0, "R6", "full before capacity", n, DEPTH);
      wr_step(1, 16'h1000 + n[DW-1:0], acc);
      if (acc) n++;
    end
    wr_step(0, '0, acc);
    repeat (3) wr_step(0, '0, acc);
    check(full === 1'b1, "R4", "full at capacity", full, 1);
    for (int i = 0; i < 4; i++) begin
      wr_step(1, 16'hDEAD, acc);
      check(acc == 1'b0 && full === 1'b1, "R4", "write while full dropped", acc, 0);
    end
    wr_step(0, '0, acc);

    // R7: one read releases full within a bounded time
    rd_step(1);
    rd_step(0);
    n = 0;
    while (full && n < 12) begin @(posedge wclk); #1; n++; end
    check(full === 1'b0, "R7", "full release latency", n, 12);

    // drain everything; a stray 0xDEAD would break the order check
    repeat (DEPTH + 8) rd_step(!empty);
    rd_step(0);
    check(sb.size() == 0, "R4", "words left after drain", sb.size(), 0);
    check(nrd == DEPTH, "R2", "words read after fill", nrd, DEPTH);
    check(empty === 1'b1, "R6", "empty after drain", empty, 1);

    // R7: empty release after single write (pointer now wrapped once)
    wr_step(1, 16'h5A5A, acc);
    wr_step(0, '0, acc);
    n = 0;
    while (empty && n < 12) begin @(posedge rclk); #1; n++; end
    check(empty === 1'b0, "R7", "empty release latency", n, 12);
    rd_step(1);
    rd_step(0);
    rd_step(0);

    // R9: bursty random traffic, multiple wraps
    nwr = 0; nrd = 0;
    fork
      begin : writer
        bit a;
        int sent = 0;
        while (sent < 1500) begin
          int len = $urandom_range(1, 40);
          for (int k = 0; k < len && sent < 1500; k++) begin
            wr_step(($urandom_range(0, 9) < 8), DW'($urandom), a);
            if (a) sent++;
          end
          wr_step(0, '0, a);
          repeat ($urandom_range(0, 30)) wr_step(0, '0, a);
        end
        wr_step(0, '0, a);
        wdone = 1;
      end
      begin : reader
        while (!wdone || sb.size() > 0 || pend) begin
          int len = $urandom_range(1, 50);
          for (int k = 0; k < len; k++) rd_step(($urandom_range(0, 9) < 7));
          repeat ($urandom_range(0, 20)) rd_step(0);
        end
        rd_step(0);
      end
    join
    check(nrd == nwr && nwr == 1500, "R9", "words through random phase", nrd, nwr);
    repeat (6) @(posedge wclk);
    #1;
    check(empty === 1'b1 && full === 1'b0, "R9", "flags after random phase", {empty, full}, 2'b10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule